// File: doc/BRIEF.md
# Programmable Length Delay Buffer

This block delays a stream of 10-bit words by a programmable number of clock cycles. A length word L sets the total delay N = L + 2. Every word passes an input register, then a variable section of L stages held in a circular RAM, then an output register. When L is zero the RAM is skipped and only the two registers remain. The delay therefore runs from 2 to 1281 cycles.

A mode input turns the same storage into a loop. The output is fed back to the input register, so the N words in flight circulate for as long as the mode stays set. Two control inputs are registered before they act. One is the mode select. The other is an active-high hold that freezes every register and the RAM pointer. An active-low output enable either drives the data port or releases it to high impedance. The enable has no effect on the data moving inside the block.

All logic uses the rising clock edge. A synchronous active-high reset clears the registers, sets the length to 0 and selects delay mode.

Top module: `prog_delay_line`

## Requirements
- R1: While `rst` is sampled high, the next edge clears both data registers, sets the length to 0, selects delay mode and clears hold; with `oe_n` low the output then reads 0.
- R2: In delay mode, take the active edges in order, leaving out every edge that is frozen by R9. A word taken from `din` on active edge k appears on `dout` right after active edge k+N−1, where N = L+2 and L is the unsigned value of `len_in[10:0]` with bit 10 as MSB.
- R3: A length of 0 gives the minimum delay N = 2, and the RAM section is bypassed.
- R4: Lengths 65, 118 and 1279 give total delays of 67, 120 and 1281 cycles.
- R5: A `len_in` value above 1279 is stored as 1279.
- R6: The length register takes `len_in` only on an active edge where `len_load` is high. On every other edge it keeps its value, and that includes a load requested while the block is frozen.
- R7: In recirculate mode (`mode_recirc` captured high), the input register takes the word on `dout` instead of `din`. The output then repeats with period N.
- R8: `mode_recirc` is captured on one active edge, and the captured value chooses the input source from the following active edge onward.
- R9: If `hold` is sampled high on an edge, the next edge leaves all data, length, mode and pointer state unchanged. The edge that samples `hold` still acts normally.
- R10: With `oe_n` high every bit of `dout` is high impedance. Data keeps moving inside, and once `oe_n` returns low the output matches the stream as if the port had never been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 10 | Input data word |
| len_in | input | 11 | Length word L, bit 10 MSB; total delay is L+2 |
| len_load | input | 1 | Captures `len_in` on an active edge |
| mode_recirc | input | 1 | 0 = delay line, 1 = circular buffer (registered) |
| hold | input | 1 | Active-high freeze, takes effect one edge later |
| oe_n | input | 1 | Active-low output enable |
| dout | output | 10 | Delayed data word, high impedance when `oe_n` is high |

## Verification
The assertions assume that `rst` is high on the first clock edge. They also assume that every control input changes only between edges, so each edge sees one stable sample. The bench drives all inputs at the falling edge and holds reset for several cycles at start-up. It compares the output only where the value that leaves the RAM was written after reset and after the latest length change. Random lengths above 1279 reach the clamp only through the explicit R5 case. The checks on the hold assertion therefore cover a frozen load request, and the clamp is covered by that one case.

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int DW      = 10,
  parameter int LW      = 11,
  parameter int MAX_LEN = 1279
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din,
  input  logic [LW-1:0] len_in,
  input  logic          len_load,
  input  logic          mode_recirc,
  input  logic          hold,
  input  logic          oe_n,
  output logic [DW-1:0] dout
);
  localparam int DEPTH = MAX_LEN + 1;
  localparam int AW    = $clog2(DEPTH);

  logic          hold_q, mode_q, en;
  logic [LW-1:0] len_q, len_sat;
  logic [DW-1:0] in_q, out_q, tap;
  logic [AW-1:0] wp, rp;
  logic [AW:0]   rsum;
  logic [DW-1:0] mem [DEPTH];

  assign en      = ~hold_q;
  assign len_sat = (len_in > LW'(MAX_LEN)) ? LW'(MAX_LEN) : len_in;
  assign rsum    = (AW+1)'(wp) + (AW+1)'(DEPTH) - (AW+1)'(len_q);
  assign rp      = (rsum >= (AW+1)'(DEPTH)) ? AW'(rsum - (AW+1)'(DEPTH)) : AW'(rsum);
  assign tap     = (len_q == '0) ? in_q : mem[rp];
  assign dout    = oe_n ? {DW{1'bz}} : out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      mode_q <= 1'b0;
      len_q  <= '0;
      in_q   <= '0;
      out_q  <= '0;
      wp     <= '0;
    end else begin
      hold_q <= hold;
      if (en) begin
        mode_q <= mode_recirc;
        if (len_load) len_q <= len_sat;
        in_q   <= mode_q ? out_q : din;
        out_q  <= tap;
        wp     <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && en) mem[wp] <= in_q;
  end
endmodule

// File: rtl/prog_delay_line_chk.sv
module prog_delay_line_chk #(
  parameter int DW      = 10,
  parameter int LW      = 11,
  parameter int MAX_LEN = 1279,
  parameter int AW      = 11
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] din,
  input logic [LW-1:0] len_in,
  input logic          len_load,
  input logic          hold_q,
  input logic          mode_q,
  input logic [LW-1:0] len_q,
  input logic [DW-1:0] in_q,
  input logic [DW-1:0] out_q,
  input logic [AW-1:0] wp
);
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst) len_q <= LW'(MAX_LEN)); // R5
  AST_LEN_KEEP: assert property (@(posedge clk) disable iff (rst) !len_load |=> $stable(len_q)); // R6
  AST_LEN_TAKE: assert property (@(posedge clk) disable iff (rst)
    (len_load && !hold_q && len_in <= LW'(MAX_LEN)) |=> len_q == $past(len_in)); // R6
  AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
    hold_q |=> ($stable(out_q) && $stable(in_q) && $stable(wp) && $stable(mode_q) && $stable(len_q))); // R9
  AST_DELAY_SRC: assert property (@(posedge clk) disable iff (rst)
    (!mode_q && !hold_q) |=> in_q == $past(din)); // R8
  AST_RECIRC_SRC: assert property (@(posedge clk) disable iff (rst)
    (mode_q && !hold_q) |=> in_q == $past(out_q)); // R7
  AST_MIN_PATH: assert property (@(posedge clk) disable iff (rst)
    (len_q == '0 && !hold_q) |=> out_q == $past(in_q)); // R3
endmodule

bind prog_delay_line prog_delay_line_chk #(.DW(DW), .LW(LW), .MAX_LEN(MAX_LEN), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .din(din), .len_in(len_in), .len_load(len_load),
  .hold_q(hold_q), .mode_q(mode_q), .len_q(len_q), .in_q(in_q), .out_q(out_q), .wp(wp)
);

// File: tb/sim_prog_delay_line.sv
module sim_prog_delay_line;
  localparam int CLK_PERIOD = 10;
  localparam int HMAX = 16384;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] din = '0;
  logic [10:0] len_in = '0;
  logic       len_load = 1'b0;
  logic       mode_recirc = 1'b0;
  logic       hold = 1'b0;
  logic       oe_n = 1'b0;
  wire  [9:0] dout_w;

  for (genvar i = 0; i < 10; i++) begin : g_pu
    pullup pu (dout_w[i]);
  end

  prog_delay_line u0 (
    .clk(clk), .rst(rst), .din(din), .len_in(len_in), .len_load(len_load),
    .mode_recirc(mode_recirc), .hold(hold), .oe_n(oe_n), .dout(dout_w)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, tcount = 0;
  bit done = 0;
  string phase = "R1";

  logic [9:0] hist [HMAX];
  bit         hok  [HMAX];
  int  ec = 0, vstart = 0, m_len = 0;
  bit  m_hold = 0, m_mode = 0, m_valid = 1;
  logic [9:0] m_out = '0;

  task automatic chk(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at tick %0d", tag, act, exp, tcount);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    tcount++;
    if (rst) begin
      m_hold = 0; m_mode = 0; m_len = 0; m_out = '0; m_valid = 1; vstart = ec;
    end else begin
      bit en;
      en = !m_hold;
      m_hold = hold;
      if (en) begin
        int idx;
        idx = ec - (m_len + 1);
        hist[ec] = m_mode ? m_out : din;
        hok[ec]  = m_mode ? m_valid : 1'b1;
        if (idx >= vstart) begin m_out = hist[idx]; m_valid = hok[idx]; end
        else m_valid = 0;
        m_mode = mode_recirc;
        if (len_load) begin
          m_len = (len_in > 11'd1279) ? 1279 : int'(len_in);
          vstart = ec;
        end
        ec++;
      end
    end
    @(negedge clk);
    if (!oe_n && m_valid) chk(phase, dout_w, m_out);
    din = 10'(tcount * 613 + 77) ^ 10'(tcount >> 4);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic load_len(input int v);
    len_in = 11'(v); len_load = 1'b1; tick(); len_load = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [9:0] frz;
    logic [9:0] ring [8];
    @(negedge clk);
    phase = "R1";
    run(3);
    chk("R1 reset output", dout_w, 10'h000);
    rst = 1'b0;
    phase = "R3 len0";
    run(30);
    phase = "R2 len1";  load_len(1);  run(40);
    phase = "R2 len2";  load_len(2);  run(40);
    phase = "R2 len5";  load_len(5);  run(40);
    phase = "R4 len65"; load_len(65); run(100);
    phase = "R4 len118"; load_len(118); run(160);
    phase = "R4 len1279"; load_len(1279); run(1320);
    phase = "R3 back0"; load_len(0); run(20);
    phase = "R2 len5"; load_len(5); run(20);
    phase = "R5 clamp"; load_len(2047); run(1320);
    phase = "R6 keep";  load_len(5); run(20);
    len_in = 11'd9; run(30);
    phase = "R9 hold";
    hold = 1'b1; tick();
    frz = dout_w;
    len_in = 11'd3; len_load = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R9 frozen output", dout_w, frz);
    end
    len_load = 1'b0; hold = 1'b0;
    phase = "R6 R9 after hold"; run(30);
    phase = "R8 mode switch";
    mode_recirc = 1'b1; run(12);
    phase = "R7 recirc";
    for (int i = 0; i < 7; i++) begin tick(); ring[i] = dout_w; end
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < 7; i++) begin
        tick();
        chk("R7 period N", dout_w, ring[i]);
      end
    mode_recirc = 1'b0;
    phase = "R8 back to delay"; run(30);
    phase = "R10 released";
    oe_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick();
      chk("R10 high impedance", dout_w, 10'h3ff);
    end
    oe_n = 1'b0;
    phase = "R10 resumed"; run(20);
    phase = "R1 reset again";
    rst = 1'b1; tick();
    chk("R1 reset output", dout_w, 10'h000);
    rst = 1'b0; phase = "R3 after reset"; run(20);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule